// File: doc/BRIEF.md
# Loop Port Bypass Chain

This block models, word by word on a parallel bus, a serial loop that runs through a ring of port cells. Every cell except one serves an attached node. In loop, the cell sends the loop stream out to its node and carries the node's returned stream onward. Bypassed, it passes the stream it received straight on and skips the node. One cell is the cable cell. Its incoming side is the chain's loop input and its outgoing side is the chain's loop output, so several chains can be joined end to end into a longer loop.

An optional retiming stage stands in for clock recovery. When the stage is switched in, the loop input is delayed by one register before it enters the first node cell. All outputs come from registers. A change on any control therefore shows at the ports one clock later, and every word it produces is a complete word.

Top module: `lpb_chain`

## Requirements
- R1: While `rst` is high at a clock edge, `loop_out` and every lane of `to_node` become zero. The retiming register also becomes zero.
- R2: When a node cell's `bypass_n` bit is 1 (in loop), the stream leaving that cell is that cell's `from_node` lane.
- R3: When a node cell's `bypass_n` bit is 0 (bypassed), the stream leaving that cell is the stream arriving at it, and its `from_node` lane has no effect on any output.
- R4: Each node cell's `to_node` lane carries the stream arriving at that cell, whether or not the cell is bypassed.
- R5: The loop enters the cell with index CABLE_CELL+1 and visits the cells in rising index order, wrapping modulo NUM_CELLS. `loop_out` is the stream leaving the cell just before the cable cell.
- R6: The cable cell's `bypass_n` bit and its `from_node` lane have no effect. Its `to_node` lane always equals `loop_out`.
- R7: With `retime_en` low, a word on `loop_in` reaches `loop_out` (all node cells bypassed) one clock later. With `retime_en` high, it arrives two clocks later. Node-to-loop paths always take one clock.
- R8: The retiming register takes in `loop_in` on every non-reset edge, whatever `retime_en` is. Switching it in therefore first yields the previous cycle's input word.
- R9: A change of `bypass_n` or `retime_en` takes effect on the outputs at the next clock edge, with no intermediate word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retime_en | input | 1 | 1 puts the retiming register in the loop input path |
| bypass_n | input | NUM_CELLS | Per cell: 1 = node in loop, 0 = node bypassed |
| loop_in | input | DATA_W | Stream entering the chain at the cable cell |
| loop_out | output | DATA_W | Stream leaving the chain at the cable cell |
| from_node | input | NUM_CELLS*DATA_W | Return stream of each node, lane i at bits i*DATA_W upward |
| to_node | output | NUM_CELLS*DATA_W | Stream sent to each node, lane i at bits i*DATA_W upward |

## Verification
Every source word carries a tag naming its origin, so a wrong select in any cell shows up at the next clock. The wrong word appears on `loop_out` and on the `to_node` lanes of all later cells, and the tag tells which cell misrouted. A retiming register that holds, skips or is wired in the wrong place shows as a loop-input tag that is one cycle off. This is visible the first cycle the loop input reaches an output. Sweeping every bypass pattern against both retime settings, and changing the settings every cycle, also exposes any control that acts a cycle late.

// File: rtl/lpb_pkg.sv
package lpb_pkg;
  function automatic int lpb_wrap(input int value, input int modulus);
    return value % modulus;
  endfunction
endpackage

// File: rtl/lpb_retimer.sv
module lpb_retimer #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else     hold_q <= d;
  end

  assign q = en ? hold_q : d;
endmodule

// File: rtl/lpb_cell.sv
module lpb_cell #(
  parameter int DATA_W = 16
) (
  input  logic              in_loop,
  input  logic [DATA_W-1:0] arrive,
  input  logic [DATA_W-1:0] node_ret,
  output logic [DATA_W-1:0] depart
);
  assign depart = in_loop ? node_ret : arrive;
endmodule

// File: rtl/lpb_chain.sv
module lpb_chain #(
  parameter int DATA_W     = 16,
  parameter int NUM_CELLS  = 5,
  parameter int CABLE_CELL = 0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          retime_en,
  input  logic [NUM_CELLS-1:0]          bypass_n,
  input  logic [DATA_W-1:0]             loop_in,
  output logic [DATA_W-1:0]             loop_out,
  input  logic [NUM_CELLS*DATA_W-1:0]   from_node,
  output logic [NUM_CELLS*DATA_W-1:0]   to_node
);
  import lpb_pkg::*;

  localparam int NODES = NUM_CELLS - 1;
  localparam int FIRST = lpb_wrap(CABLE_CELL + 1, NUM_CELLS);
  localparam int LAST  = lpb_wrap(CABLE_CELL + NUM_CELLS - 1, NUM_CELLS);
  localparam logic [NUM_CELLS-1:0] NODE_MASK =
    ~({{(NUM_CELLS-1){1'b0}}, 1'b1} << CABLE_CELL);

  logic [DATA_W-1:0] stream [0:NODES];
  logic [DATA_W-1:0] arrive [0:NUM_CELLS-1];

  lpb_retimer #(.DATA_W(DATA_W)) u_retimer (
    .clk (clk),
    .rst (rst),
    .en  (retime_en),
    .d   (loop_in),
    .q   (stream[0])
  );

  for (genvar s = 0; s < NODES; s++) begin : g_stage
    localparam int IDX = lpb_wrap(CABLE_CELL + 1 + s, NUM_CELLS);
    assign arrive[IDX] = stream[s];
    lpb_cell #(.DATA_W(DATA_W)) u_cell (
      .in_loop  (bypass_n[IDX]),
      .arrive   (stream[s]),
      .node_ret (from_node[IDX*DATA_W +: DATA_W]),
      .depart   (stream[s+1])
    );
  end

  assign arrive[CABLE_CELL] = stream[NODES];

  logic unused_cable_inputs;
  assign unused_cable_inputs = ^{bypass_n[CABLE_CELL],
                                 from_node[CABLE_CELL*DATA_W +: DATA_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      loop_out <= '0;
      to_node  <= '0;
    end else begin
      loop_out <= stream[NODES];
      for (int i = 0; i < NUM_CELLS; i++) begin
        to_node[i*DATA_W +: DATA_W] <= arrive[i];
      end
    end
  end

  // Cycles since reset, saturating at 2, used to guard $past in assertions
  logic [1:0] live_q;
  always_ff @(posedge clk) begin
    if (rst)              live_q <= '0;
    else if (live_q != 2) live_q <= live_q + 2'd1;
  end

  a_r2_last_in_loop: assert property (@(posedge clk) disable iff (rst)
    (live_q != 0 && $past(bypass_n[LAST]))
      |-> loop_out == $past(from_node[LAST*DATA_W +: DATA_W]));

  a_r3_all_bypassed: assert property (@(posedge clk) disable iff (rst)
    (live_q != 0 && $past((bypass_n & NODE_MASK) == '0) && !$past(retime_en))
      |-> loop_out == $past(loop_in));

  a_r4_first_tap: assert property (@(posedge clk) disable iff (rst)
    (live_q != 0 && !$past(retime_en))
      |-> to_node[FIRST*DATA_W +: DATA_W] == $past(loop_in));

  a_r7_retimed_latency: assert property (@(posedge clk) disable iff (rst)
    (live_q == 2 && $past(retime_en) && $past((bypass_n & NODE_MASK) == '0))
      |-> loop_out == $past(loop_in, 2));
endmodule

// File: tb/test_lpb_chain.sv
`timescale 1ns/1ps
module test_lpb_chain;
  localparam int W = 16;
  localparam int N = 5;

  logic           clk = 1'b0;
  logic           rst;
  logic           retime_en;
  logic [N-1:0]   bypass_n;
  logic [W-1:0]   loop_in;
  logic [W-1:0]   loop_out;
  logic [N*W-1:0] from_node;
  logic [N*W-1:0] to_node;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lpb_chain #(.DATA_W(W), .NUM_CELLS(N), .CABLE_CELL(0)) i_lpb_chain (
    .clk(clk), .rst(rst), .retime_en(retime_en), .bypass_n(bypass_n),
    .loop_in(loop_in), .loop_out(loop_out),
    .from_node(from_node), .to_node(to_node)
  );

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] prev_li;
    logic [W-1:0] cur;
    logic [W-1:0] exp_to [0:N-1];

    rst = 1'b1; retime_en = 1'b1; bypass_n = '1;
    loop_in = 16'hA5A5; from_node = {N{16'h5A5A}};
    repeat (3) @(posedge clk);
    #1;
    check("R1 loop_out reset", loop_out, '0);
    for (int k = 0; k < N; k++) check("R1 to_node reset", to_node[k*W +: W], '0);

    @(negedge clk);
    rst = 1'b0;
    prev_li = '0;
    for (int c = 0; c < 256; c++) begin
      retime_en = c[0];
      bypass_n  = c[5:1];
      loop_in   = 16'hA000 | W'(c);
      for (int k = 0; k < N; k++)
        from_node[k*W +: W] = W'((k + 1) << 12) | W'(c);
      @(posedge clk);
      #1;
      // Expected path: loop input (retimed or not) through cells 1..4 in order
      cur = retime_en ? prev_li : loop_in;
      for (int k = 1; k < N; k++) begin
        exp_to[k] = cur;
        if (bypass_n[k]) cur = from_node[k*W +: W];
      end
      if (retime_en && bypass_n[4:1] == '0)
        check("R7 R8 retimed loop input", loop_out, cur);
      else if (bypass_n[4:1] == '0)
        check("R3 R7 all bypassed", loop_out, cur);
      else
        check("R2 R5 R9 loop_out", loop_out, cur);
      for (int k = 1; k < N; k++)
        check("R4 R3 to_node lane", to_node[k*W +: W], exp_to[k]);
      check("R6 cable lane", to_node[0 +: W], cur);
      prev_li = loop_in;
      @(negedge clk);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule